// File: doc/BRIEF.md
# Cell Framer with Command-Byte Insertion

This block turns 53-byte cells into a stream of 4-bit nibbles for a line transmitter. An upstream writer hands it bytes one at a time. They go into a buffer organised as three cell slots. A cell is only sent once all 53 of its bytes are held. Every cell goes out high nibble first and is led by a two-nibble command byte. That byte is escape followed by escape when the downstream scrambler must restart. It is escape followed by the code 4 otherwise.

The framer decides when a restart is needed. It counts every nibble it emits, commands included, since the last restarting command. When that count reaches the scrambler period (default 1023), the next cell start requests a restart. The first cell after reset always requests one.

A one-cycle sync pulse from an 8 kHz timebase is latched. It is answered with a timing marker: escape followed by the code 8. The marker goes out at the next byte boundary, even in the middle of a cell. A pulse seen while a command byte is on the line waits until that command byte is complete. Each output nibble carries flags marking it as command or escape, so the scrambler can leave command bytes untouched.

Top module: `cell_framer`

## Requirements
- R1: While reset is held and after its release, `tx_valid` is low and `wr_ready` is high.
- R2: No nibble of a cell is offered until all 53 of its bytes have been accepted; with only 52 bytes held, `tx_valid` stays low.
- R3: The buffer accepts at most three complete cells; with three full cells held, `wr_ready` is low and a byte offered then is discarded and never appears at the output.
- R4: Every command byte is two nibbles. The first is an escape, flagged `tx_esc`=1 and `tx_cmd`=1 with `tx_nib`=0. The second is an escape (start with restart), or code 4 (start without restart), or code 8 (timing marker); codes 4 and 8 are flagged `tx_cmd`=1, `tx_esc`=0.
- R5: After its start command, a cell's bytes leave in write order as 106 data nibbles (`tx_cmd`=0, `tx_esc`=0), high nibble first, interrupted only by timing markers.
- R6: The first cell after reset is led by escape, escape.
- R7: A later cell is led by escape, escape exactly when at least PERIOD nibbles were accepted downstream since the second escape of the last restarting command; otherwise by escape, 4.
- R8: Each sync pulse yields one timing marker. Inside a cell, the marker begins right after the byte in progress, and the cell resumes with the following byte.
- R9: A pulse seen while a command byte is on the line is held until that command byte ends. A pending marker goes before the start command of a waiting cell.
- R10: At most one marker is pending; several pulses before it is sent produce one marker.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_nib`, `tx_cmd` and `tx_esc` hold their values.
- R12: With no complete cell buffered and no marker pending, `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Byte offered on `wr_data` |
| wr_data | input | 8 | Cell byte, cell order |
| wr_ready | output | 1 | Buffer has room; byte taken when both high |
| sync_pulse | input | 1 | One-cycle 8 kHz timing pulse |
| tx_ready | input | 1 | Downstream takes the nibble this cycle |
| tx_valid | output | 1 | A nibble is offered |
| tx_nib | output | 4 | Nibble value |
| tx_cmd | output | 1 | Nibble belongs to a command byte |
| tx_esc | output | 1 | Nibble is an escape symbol |

## Verification
A wrong nibble counter shows up at the next cell start as the wrong second command nibble. Depending on the cell rate, that can be many cells after the fault. The bench therefore runs long enough to cross several scrambler periods. A corrupted byte index or slot pointer shows up within one byte, as a data nibble that differs from the written stream. A lost or doubled pending flag shows up as a missing or extra marker. It can also appear as a marker placed between the nibbles of a byte, at the first boundary after the pulse.

// File: rtl/framer_pkg.sv
package framer_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE,
        MODE_CMD,
        MODE_DATA
    } mode_e;

    typedef enum logic [1:0] {
        CMD_SOC_RST,
        CMD_SOC_KEEP,
        CMD_MARK
    } cmd_e;

    typedef struct packed {
        logic [3:0] nib;
        logic       cmd;
        logic       esc;
    } lane_t;

    localparam logic [3:0] CODE_ESC  = 4'h0;
    localparam logic [3:0] CODE_KEEP = 4'h4;
    localparam logic [3:0] CODE_MARK = 4'h8;

    function automatic lane_t esc_lane();
        lane_t l;
        l.nib = CODE_ESC;
        l.cmd = 1'b1;
        l.esc = 1'b1;
        return l;
    endfunction

    function automatic lane_t second_lane(cmd_e k);
        lane_t l;
        l.cmd = 1'b1;
        unique case (k)
            CMD_SOC_RST:  begin l.nib = CODE_ESC;  l.esc = 1'b1; end
            CMD_SOC_KEEP: begin l.nib = CODE_KEEP; l.esc = 1'b0; end
            default:      begin l.nib = CODE_MARK; l.esc = 1'b0; end
        endcase
        return l;
    endfunction

    function automatic lane_t data_lane(logic [7:0] b, logic lo);
        lane_t l;
        l.nib = lo ? b[3:0] : b[7:4];
        l.cmd = 1'b0;
        l.esc = 1'b0;
        return l;
    endfunction

    function automatic cmd_e soc_kind(logic period_done);
        return period_done ? CMD_SOC_RST : CMD_SOC_KEEP;
    endfunction

endpackage

// File: rtl/framer_cell_store.sv
module framer_cell_store #(
    parameter int CELL_BYTES = 53,
    parameter int CELLS      = 3,
    localparam int IDX_W     = $clog2(CELL_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    output logic             wr_ready,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_release,
    output logic [7:0]       rd_data,
    output logic             cell_avail,
    output logic             cell_more
);
    localparam int SLOT_W = (CELLS > 1) ? $clog2(CELLS) : 1;
    localparam int CNT_W  = $clog2(CELLS + 1);
    localparam int DEPTH  = CELL_BYTES * CELLS;
    localparam int ADDR_W = $clog2(DEPTH);

    logic [7:0]        mem [DEPTH];
    logic [SLOT_W-1:0] wr_slot, rd_slot;
    logic [IDX_W-1:0]  wr_idx;
    logic [CNT_W-1:0]  full_cnt;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic              wr_fire, wr_last;

    function automatic logic [SLOT_W-1:0] slot_inc(logic [SLOT_W-1:0] s);
        return (s == SLOT_W'(CELLS - 1)) ? '0 : s + 1'b1;
    endfunction

    assign wr_ready   = (full_cnt != CNT_W'(CELLS));
    assign wr_fire    = wr_valid && wr_ready;
    assign wr_last    = (wr_idx == IDX_W'(CELL_BYTES - 1));
    assign wr_addr    = ADDR_W'(int'(wr_slot) * CELL_BYTES + int'(wr_idx));
    assign rd_addr    = ADDR_W'(int'(rd_slot) * CELL_BYTES + int'(rd_idx));
    assign rd_data    = mem[rd_addr];
    assign cell_avail = (full_cnt != '0);
    assign cell_more  = (full_cnt > CNT_W'(1));

    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_slot  <= '0;
            wr_idx   <= '0;
            rd_slot  <= '0;
            full_cnt <= '0;
        end else begin
            if (wr_fire) begin
                if (wr_last) begin
                    wr_idx  <= '0;
                    wr_slot <= slot_inc(wr_slot);
                end else begin
                    wr_idx <= wr_idx + 1'b1;
                end
            end
            if (rd_release) begin
                rd_slot <= slot_inc(rd_slot);
            end
            unique case ({wr_fire && wr_last, rd_release})
                2'b10:   full_cnt <= full_cnt + 1'b1;
                2'b01:   full_cnt <= full_cnt - 1'b1;
                default: full_cnt <= full_cnt;
            endcase
        end
    end

endmodule

// File: rtl/framer_period_track.sv
module framer_period_track #(
    parameter int PERIOD = 1023
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic reset_evt,
    output logic done_next
);
    localparam int CW = $clog2(PERIOD + 1);

    logic [CW-1:0] cnt, cnt_n;

    always_comb begin
        cnt_n = cnt;
        if (reset_evt) begin
            cnt_n = '0;
        end else if (fire && (cnt != CW'(PERIOD))) begin
            cnt_n = cnt + 1'b1;
        end
    end

    assign done_next = (cnt_n == CW'(PERIOD));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CW'(PERIOD);
        end else begin
            cnt <= cnt_n;
        end
    end

endmodule

// File: rtl/framer_seq.sv
module framer_seq
    import framer_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    localparam int IDX_W     = $clog2(CELL_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_pulse,
    input  logic             cell_avail,
    input  logic             cell_more,
    input  logic [7:0]       rd_data,
    input  logic             done_next,
    input  logic             tx_ready,
    output logic [IDX_W-1:0] rd_idx,
    output logic             rd_release,
    output logic             fire,
    output logic             reset_evt,
    output logic             tx_valid,
    output lane_t            lane
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_BYTES - 1);

    mode_e            mode;
    cmd_e             kind;
    logic             second, in_cell, lo_nib, pend;
    logic [IDX_W-1:0] byte_idx;
    logic             cmd_done, byte_done, cell_end, boundary, stay_in_cell, more;

    assign tx_valid     = (mode != MODE_IDLE);
    assign fire         = tx_valid && tx_ready;
    assign cmd_done     = fire && (mode == MODE_CMD) && second;
    assign byte_done    = fire && (mode == MODE_DATA) && lo_nib;
    assign cell_end     = byte_done && (byte_idx == LAST);
    assign boundary     = (mode == MODE_IDLE) || cmd_done || byte_done;
    assign stay_in_cell = in_cell && !cell_end;
    assign more         = cell_end ? cell_more : cell_avail;
    assign reset_evt    = cmd_done && (kind == CMD_SOC_RST);
    assign rd_idx       = byte_idx;
    assign rd_release   = cell_end;

    always_comb begin
        unique case (mode)
            MODE_CMD:  lane = second ? second_lane(kind) : esc_lane();
            MODE_DATA: lane = data_lane(rd_data, lo_nib);
            default:   lane = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_IDLE;
            kind     <= CMD_SOC_KEEP;
            second   <= 1'b0;
            in_cell  <= 1'b0;
            lo_nib   <= 1'b0;
            pend     <= 1'b0;
            byte_idx <= '0;
        end else begin
            if (fire && (mode == MODE_CMD) && !second) begin
                second <= 1'b1;
            end
            if (fire && (mode == MODE_DATA) && !lo_nib) begin
                lo_nib <= 1'b1;
            end
            if (byte_done) begin
                byte_idx <= cell_end ? '0 : byte_idx + 1'b1;
                if (cell_end) begin
                    in_cell <= 1'b0;
                end
            end
            if (boundary) begin
                if (pend) begin
                    mode   <= MODE_CMD;
                    kind   <= CMD_MARK;
                    second <= 1'b0;
                    pend   <= 1'b0;
                end else if (stay_in_cell) begin
                    mode   <= MODE_DATA;
                    lo_nib <= 1'b0;
                end else if (more) begin
                    mode     <= MODE_CMD;
                    kind     <= soc_kind(done_next);
                    second   <= 1'b0;
                    in_cell  <= 1'b1;
                    byte_idx <= '0;
                end else begin
                    mode <= MODE_IDLE;
                end
            end
            if (sync_pulse) begin
                pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cell_framer.sv
module cell_framer
    import framer_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int CELLS      = 3,
    parameter int PERIOD     = 1023
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    output logic       wr_ready,
    input  logic       sync_pulse,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [3:0] tx_nib,
    output logic       tx_cmd,
    output logic       tx_esc
);
    localparam int IDX_W = $clog2(CELL_BYTES);

    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;
    logic             rd_release, cell_avail, cell_more;
    logic             fire, reset_evt, done_next;
    lane_t            lane;

    framer_cell_store #(.CELL_BYTES(CELL_BYTES), .CELLS(CELLS)) u_store (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_idx(rd_idx), .rd_release(rd_release), .rd_data(rd_data),
        .cell_avail(cell_avail), .cell_more(cell_more)
    );

    framer_period_track #(.PERIOD(PERIOD)) u_period (
        .clk(clk), .rst(rst),
        .fire(fire), .reset_evt(reset_evt), .done_next(done_next)
    );

    framer_seq #(.CELL_BYTES(CELL_BYTES)) u_seq (
        .clk(clk), .rst(rst), .sync_pulse(sync_pulse),
        .cell_avail(cell_avail), .cell_more(cell_more), .rd_data(rd_data),
        .done_next(done_next), .tx_ready(tx_ready),
        .rd_idx(rd_idx), .rd_release(rd_release),
        .fire(fire), .reset_evt(reset_evt),
        .tx_valid(tx_valid), .lane(lane)
    );

    assign tx_nib = lane.nib;
    assign tx_cmd = lane.cmd;
    assign tx_esc = lane.esc;

endmodule

// File: rtl/cell_framer_chk.sv
module cell_framer_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [3:0] tx_nib,
    input logic       tx_cmd,
    input logic       tx_esc,
    input logic       wr_ready,
    input logic       cell_avail
);
    a_r11_hold_stable: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_nib) && $stable(tx_cmd) && $stable(tx_esc));

    a_r4_esc_is_cmd: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_esc |-> tx_cmd);

    a_r8_cmd_code: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_cmd && !tx_esc |-> (tx_nib == 4'h4) || (tx_nib == 4'h8));

    a_r2_data_needs_cell: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_cmd |-> cell_avail);

    a_r3_full_has_cell: assert property (@(posedge clk) disable iff (rst)
        !wr_ready |-> cell_avail);
endmodule

bind cell_framer cell_framer_chk u_chk (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_nib(tx_nib), .tx_cmd(tx_cmd), .tx_esc(tx_esc),
    .wr_ready(wr_ready), .cell_avail(cell_avail)
);

// File: tb/test_cell_framer.sv
module test_cell_framer;
    localparam int CLK_PERIOD = 10;
    localparam int CB  = 53;
    localparam int NC  = 3;
    localparam int PER = 1023;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_ready;
    logic       sync_pulse = 1'b0;
    logic       tx_ready = 1'b0;
    logic       tx_valid;
    logic [3:0] tx_nib;
    logic       tx_cmd, tx_esc;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cell_framer #(.CELL_BYTES(CB), .CELLS(NC), .PERIOD(PER)) i_cell_framer (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .sync_pulse(sync_pulse), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_nib(tx_nib), .tx_cmd(tx_cmd), .tx_esc(tx_esc)
    );

    int checks = 0, fails = 0;
    logic [7:0] q[$];
    int  wcount = 0;
    bit  last_acc = 0;
    // parser model
    bit  p_wait2 = 0, p_in_cell = 0, p_hi = 0, first_seen = 0;
    int  p_byte = 0, since = PER, since_at_cmd = 0;
    int  markers = 0, mark_byte = -1;
    bit  mark_between = 0;
    // hold model
    bit  prev_stall = 0;
    logic [5:0] prev_out = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic parse_nibble();
        if (p_wait2) begin
            p_wait2 = 0;
            if (tx_cmd && tx_esc) begin
                chk(!p_in_cell, "R5 start inside cell", p_in_cell, 0);
                chk(1'b1 == (!first_seen || since_at_cmd >= PER),
                    first_seen ? "R7 restart start" : "R6 first start", 1, 0);
                first_seen = 1; p_in_cell = 1; p_byte = 0; p_hi = 0;
                since = 0;
            end else if (tx_cmd && tx_nib == 4'h4) begin
                chk(!p_in_cell, "R5 start inside cell", p_in_cell, 0);
                chk(first_seen && since_at_cmd < PER, first_seen ? "R7 keep start" : "R6 first start",
                    since_at_cmd, PER);
                first_seen = 1; p_in_cell = 1; p_byte = 0; p_hi = 0;
                since++;
            end else if (tx_cmd && tx_nib == 4'h8) begin
                markers++; mark_byte = p_byte; mark_between = !p_in_cell;
                since++;
            end else begin
                chk(0, "R4 second command nibble", tx_nib, 8);
                since++;
            end
        end else if (tx_cmd) begin
            chk(tx_esc && tx_nib == 4'h0, "R4 first command nibble", {tx_nib, tx_esc}, 1);
            chk(!p_hi, "R8 octet boundary", p_hi, 0);
            p_wait2 = 1; since_at_cmd = since; since++;
        end else begin
            chk(!tx_esc && p_in_cell && q.size() > 0, "R5 data outside cell", p_in_cell, 1);
            if (q.size() > 0) begin
                chk(tx_nib == (p_hi ? q[0][3:0] : q[0][7:4]), "R5 data nibble",
                    tx_nib, p_hi ? q[0][3:0] : q[0][7:4]);
                if (p_hi) begin
                    void'(q.pop_front());
                    p_byte++; p_hi = 0;
                    if (p_byte == CB) p_in_cell = 0;
                end else begin
                    p_hi = 1;
                end
            end
            since++;
        end
    endtask

    // observe at negedge+1, then wait for the next negedge
    task automatic step();
        #1;
        if (!rst) begin
            if (prev_stall) begin
                chk(tx_valid && {tx_nib, tx_cmd, tx_esc} == prev_out, "R11 hold",
                    {tx_valid, tx_nib, tx_cmd, tx_esc}, {1'b1, prev_out});
            end
            prev_stall = tx_valid && !tx_ready;
            prev_out   = {tx_nib, tx_cmd, tx_esc};
            last_acc = wr_valid && wr_ready;
            if (last_acc) begin q.push_back(wr_data); wcount++; end
            if (tx_valid && tx_ready) parse_nibble();
        end
        @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] b);
        wr_valid = 1; wr_data = b;
        for (int k = 0; k < 2000; k++) begin
            step();
            if (last_acc) break;
        end
        wr_valid = 0;
    endtask

    task automatic write_cell();
        for (int i = 0; i < CB; i++) put_byte(8'($urandom));
    endtask

    task automatic pulse();
        sync_pulse = 1; step(); sync_pulse = 0;
    endtask

    task automatic drain();
        tx_ready = 1;
        for (int k = 0; k < 20000; k++) begin
            step();
            if (!tx_valid && q.size() == 0 && !p_in_cell && !p_wait2) break;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        int m0, pulses;
        bit stop;
        void'($urandom(32'd4321));
        @(negedge clk);
        repeat (3) step();
        #1;
        chk(!tx_valid && wr_ready, "R1 reset state", {tx_valid, wr_ready}, 1);
        @(negedge clk);
        rst = 0;
        step();
        chk(!tx_valid && wr_ready, "R1 after reset", {tx_valid, wr_ready}, 1);

        // R2: partial cell is held back
        tx_ready = 1;
        for (int i = 0; i < CB - 1; i++) put_byte(8'($urandom));
        repeat (8) step();
        chk(!tx_valid, "R2 partial cell", tx_valid, 0);
        put_byte(8'($urandom));
        for (int k = 0; k < 4 && !tx_valid; k++) step();
        chk(tx_valid, "R2 full cell starts", tx_valid, 1);
        drain();
        chk(first_seen, "R6 first cell seen", first_seen, 1);

        // R3: three cells fill the buffer, extra bytes are dropped
        tx_ready = 0;
        repeat (NC) write_cell();
        wr_valid = 1;
        for (int i = 0; i < 5; i++) begin
            wr_data = 8'($urandom);
            step();
            chk(!wr_ready && !last_acc, "R3 full buffer", wr_ready, 0);
        end
        wr_valid = 0;
        drain();
        chk(q.size() == 0 && wcount == 4 * CB, "R3 extra bytes discarded", wcount, 4 * CB);

        // R10 and R8: several pulses during a stall mid-byte give one marker after that byte
        tx_ready = 1;
        write_cell();
        for (int k = 0; k < 3000; k++) begin
            if (p_in_cell && p_hi && p_byte == 10) break;
            step();
        end
        tx_ready = 0;
        m0 = markers;
        pulse(); pulse(); pulse();
        step(); step();
        drain();
        chk(markers - m0 == 1, "R10 one marker", markers - m0, 1);
        chk(mark_byte == 11 && !mark_between, "R8 marker after byte", mark_byte, 11);

        // R9: pulse while start command is on the line
        tx_ready = 0;
        write_cell();
        step(); step(); step();
        m0 = markers;
        pulse();
        drain();
        chk(markers - m0 == 1 && mark_byte == 0 && !mark_between, "R9 held past command",
            mark_byte, 0);

        // R9: pending marker beats the next cell start
        tx_ready = 0;
        write_cell();
        write_cell();
        tx_ready = 1;
        for (int k = 0; k < 3000; k++) begin
            if (p_in_cell && p_hi && p_byte == CB - 1) break;
            step();
        end
        tx_ready = 0;
        m0 = markers;
        pulse();
        drain();
        chk(markers - m0 == 1 && mark_between, "R9 marker before start", mark_between, 1);

        // random traffic across several scrambler periods
        m0 = markers; pulses = 0; stop = 0;
        for (int c = 0; c < 30000; c++) begin
            tx_ready = (($urandom % 10) < 7);
            stop = (c > 29000);
            wr_valid = (!stop && ($urandom % 2)) || (stop && (wcount % CB) != 0);
            wr_data = 8'($urandom);
            sync_pulse = (c % 500 == 250);
            if (sync_pulse) pulses++;
            step();
        end
        wr_valid = 0; sync_pulse = 0;
        drain();
        chk(markers - m0 == pulses, "R8 marker per pulse", markers - m0, pulses);
        chk(q.size() == 0, "R5 all data sent", q.size(), 0);

        // R12: nothing to send
        for (int i = 0; i < 20; i++) begin
            step();
            chk(!tx_valid, "R12 idle", tx_valid, 0);
        end
        summary();
    end
endmodule